// File: doc/BRIEF.md
# Daisy-Chained Bus Acquisition Controller

This controller sits between a DMA engine and a shared system bus whose ownership is handed down a priority daisy chain. When the engine signals that it has work, the controller raises a bus request and waits for the active-low chain grant. Once the grant is seen, it tells the engine that it owns the bus. It keeps the request up for the whole tenure and ends the tenure when the engine runs out of work, when a programmable number of transfers has been made, when the grant is taken back, or when an abort is signalled.

A device that is not requesting does not consume the grant. It passes the grant through to the next device in the chain for as long as the grant stays low. A device that is requesting, or that holds the bus, keeps its downstream grant high. Every tenure is closed by a one-cycle completion pulse that carries a cause code. After that pulse the request stays low for at least one clock before a new request may start.

Top module: `busacq_top`

## Requirements
- R1: While reset is high and on the first cycle after it, `bus_req_o`, `own_o` and `end_o` are low.
- R2: When the controller is idle and `want_i` is high at a clock edge, `bus_req_o` is high from the next cycle. It stays high while waiting for the grant and for the whole tenure.
- R3: There is no minimum wait after the request: a low `grant_in_n` sampled at any edge while waiting starts the tenure. `own_o` is high from the next cycle, but only while `bus_req_o` is high, `grant_in_n` is low and `abort_n` is high.
- R4: `own_o` goes low in the same cycle in which `grant_in_n` goes high or `abort_n` goes low.
- R5: If `want_i` is low at an edge during a tenure and no other end condition holds, the tenure ends with cause code 0 (work done). A drop of `want_i` while waiting also ends the request with code 0.
- R6: The value of `dwell_lim_i` taken at the start of a tenure caps the number of transfers. The tenure ends with cause code 1 at the edge where the Nth counted `xfer_i` pulse is sampled. A value of 0 means no cap.
- R7: An `xfer_i` pulse counts only in a cycle where `own_o` is high.
- R8: A high `grant_in_n` during a tenure ends it with code 2. A low `abort_n` while waiting or owning ends it with code 3. When several conditions hold at once, the priority is abort, then grant withdrawn, then limit, then work done.
- R9: `end_o` is high for exactly the one cycle after the ending edge, with `cause_o` valid. In that cycle `bus_req_o` is low, and `bus_req_o` stays low in the cycle after it as well.
- R10: `grant_out_n` is low exactly when `grant_in_n` is low and `bus_req_o` is low.
- R11: Changing `dwell_lim_i` during a tenure has no effect on that tenure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| want_i | input | 1 | Engine has work and wants the bus |
| xfer_i | input | 1 | Engine completes one transfer this cycle |
| dwell_lim_i | input | CNT_W | Transfers allowed per tenure, 0 = no cap |
| grant_in_n | input | 1 | Chain grant from upstream, active low |
| abort_n | input | 1 | Abort, active low |
| bus_req_o | output | 1 | Bus request |
| grant_out_n | output | 1 | Chain grant to downstream, active low |
| own_o | output | 1 | Engine owns the bus this cycle |
| end_o | output | 1 | One-cycle pulse: tenure or request ended |
| cause_o | output | 2 | End cause: 0 done, 1 limit, 2 grant withdrawn, 3 abort |

## Verification
`grant_out_n` and `own_o` respond within the same cycle as `grant_in_n` and `abort_n`. `bus_req_o`, `end_o`, `cause_o` and the start of ownership follow the sampling edge by one register, and the tenure count is fixed at the edge that starts the tenure. The bench therefore drives inputs just after a falling edge and compares the combinational outputs a moment later, before that cycle's rising edge. Its behavioural model then advances across the rising edge, so every registered result is checked in the following cycle.

// File: rtl/busacq_pkg.sv
package busacq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WAIT = 2'd1,
        PH_HELD = 2'd2,
        PH_REST = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        END_DONE    = 2'd0,
        END_LIMIT   = 2'd1,
        END_REVOKED = 2'd2,
        END_ABORT   = 2'd3
    } end_cause_e;

    typedef struct packed {
        logic abort;
        logic revoke;
        logic limit;
        logic done;
    } end_req_t;

    function automatic logic any_end(end_req_t r);
        return r.abort | r.revoke | r.limit | r.done;
    endfunction

    function automatic end_cause_e pick_cause(end_req_t r);
        if (r.abort)       return END_ABORT;
        else if (r.revoke) return END_REVOKED;
        else if (r.limit)  return END_LIMIT;
        else               return END_DONE;
    endfunction

endpackage

// File: rtl/busacq_dwell.sv
module busacq_dwell #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] lim_i,
    input  logic             step_i,
    output logic             last_o
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] left_q;
    logic             free_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
            free_q <= 1'b1;
        end else if (load_i) begin
            left_q <= lim_i;
            free_q <= (lim_i == '0);
        end else if (step_i && !free_q) begin
            left_q <= left_q - ONE;
        end
    end

    assign last_o = !free_q && (left_q == ONE);
endmodule

// File: rtl/busacq_chain.sv
module busacq_chain (
    input  logic grant_in_n,
    input  logic abort_n,
    input  logic req_i,
    input  logic held_i,
    output logic grant_out_n,
    output logic own_o
);
    assign grant_out_n = grant_in_n | req_i;
    assign own_o       = held_i & req_i & ~grant_in_n & abort_n;
endmodule

// File: rtl/busacq_fsm.sv
module busacq_fsm
    import busacq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       want_i,
    input  logic       xfer_i,
    input  logic       grant_low_i,
    input  logic       abort_n,
    input  logic       own_i,
    input  logic       last_i,
    output logic       load_o,
    output logic       req_o,
    output logic       held_o,
    output logic       end_o,
    output logic [1:0] cause_o
);
    phase_e     phase_q, phase_d;
    end_cause_e cause_q, cause_d;
    end_req_t   wait_end, held_end;

    always_comb begin
        wait_end        = '0;
        wait_end.abort  = !abort_n;
        wait_end.done   = !want_i;

        held_end        = '0;
        held_end.abort  = !abort_n;
        held_end.revoke = !grant_low_i;
        held_end.limit  = xfer_i & own_i & last_i;
        held_end.done   = !want_i;
    end

    always_comb begin
        phase_d = phase_q;
        cause_d = cause_q;
        load_o  = 1'b0;
        unique case (phase_q)
            PH_IDLE: if (want_i) phase_d = PH_WAIT;
            PH_WAIT: begin
                if (any_end(wait_end)) begin
                    phase_d = PH_REST;
                    cause_d = pick_cause(wait_end);
                end else if (grant_low_i) begin
                    phase_d = PH_HELD;
                    load_o  = 1'b1;
                end
            end
            PH_HELD: begin
                if (any_end(held_end)) begin
                    phase_d = PH_REST;
                    cause_d = pick_cause(held_end);
                end
            end
            PH_REST: phase_d = PH_IDLE;
            default: phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cause_q <= END_DONE;
        end else begin
            phase_q <= phase_d;
            cause_q <= cause_d;
        end
    end

    assign req_o   = (phase_q == PH_WAIT) || (phase_q == PH_HELD);
    assign held_o  = (phase_q == PH_HELD);
    assign end_o   = (phase_q == PH_REST);
    assign cause_o = cause_q;
endmodule

// File: rtl/busacq_top.sv
module busacq_top
    import busacq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             want_i,
    input  logic             xfer_i,
    input  logic [CNT_W-1:0] dwell_lim_i,
    input  logic             grant_in_n,
    input  logic             abort_n,
    output logic             bus_req_o,
    output logic             grant_out_n,
    output logic             own_o,
    output logic             end_o,
    output logic [1:0]       cause_o
);
    logic load, held, last, step;

    assign step = xfer_i & own_o;

    busacq_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .want_i      (want_i),
        .xfer_i      (xfer_i),
        .grant_low_i (!grant_in_n),
        .abort_n     (abort_n),
        .own_i       (own_o),
        .last_i      (last),
        .load_o      (load),
        .req_o       (bus_req_o),
        .held_o      (held),
        .end_o       (end_o),
        .cause_o     (cause_o)
    );

    busacq_dwell #(.CNT_W(CNT_W)) u_dwell (
        .clk    (clk),
        .rst    (rst),
        .load_i (load),
        .lim_i  (dwell_lim_i),
        .step_i (step),
        .last_o (last)
    );

    busacq_chain u_chain (
        .grant_in_n  (grant_in_n),
        .abort_n     (abort_n),
        .req_i       (bus_req_o),
        .held_i      (held),
        .grant_out_n (grant_out_n),
        .own_o       (own_o)
    );
endmodule

// File: rtl/busacq_checker.sv
module busacq_checker (
    input logic       clk,
    input logic       rst,
    input logic       grant_in_n,
    input logic       abort_n,
    input logic       bus_req_o,
    input logic       grant_out_n,
    input logic       own_o,
    input logic       end_o,
    input logic [1:0] cause_o
);
    AST_OWN_NEEDS_GRANT: assert property (@(posedge clk) disable iff (rst)
        own_o |-> (bus_req_o && !grant_in_n)); // R3
    AST_REVOKE_DROPS_OWN: assert property (@(posedge clk) disable iff (rst)
        grant_in_n |-> !own_o); // R4
    AST_ABORT_DROPS_OWN: assert property (@(posedge clk) disable iff (rst)
        !abort_n |-> !own_o); // R4
    AST_ABORT_ENDS: assert property (@(posedge clk) disable iff (rst)
        (bus_req_o && !abort_n) |=> (end_o && cause_o == 2'd3)); // R8
    AST_END_IN_GAP: assert property (@(posedge clk) disable iff (rst)
        end_o |-> !bus_req_o); // R9
    AST_GAP_HOLDS: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_req_o) |=> !bus_req_o); // R9
    AST_END_SINGLE: assert property (@(posedge clk) disable iff (rst)
        end_o |=> !end_o); // R9
    AST_GRANT_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        bus_req_o |-> grant_out_n); // R10
endmodule

bind busacq_top busacq_checker u_checker (
    .clk         (clk),
    .rst         (rst),
    .grant_in_n  (grant_in_n),
    .abort_n     (abort_n),
    .bus_req_o   (bus_req_o),
    .grant_out_n (grant_out_n),
    .own_o       (own_o),
    .end_o       (end_o),
    .cause_o     (cause_o)
);

// File: tb/tb_busacq_top.sv
module tb_busacq_top;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             want_i = 1'b0;
    logic             xfer_i = 1'b0;
    logic [CNT_W-1:0] dwell_lim_i = '0;
    logic             grant_in_n = 1'b1;
    logic             abort_n = 1'b1;
    logic             bus_req_o, grant_out_n, own_o, end_o;
    logic [1:0]       cause_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // behavioural reference: 0 idle, 1 waiting, 2 holding, 3 resting
    int m_ph = 0;
    int m_left = 0;
    bit m_free = 1'b1;
    int m_cause = 0;
    string tag = "R1";

    always #4 clk = ~clk;

    busacq_top #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst(rst), .want_i(want_i), .xfer_i(xfer_i),
        .dwell_lim_i(dwell_lim_i), .grant_in_n(grant_in_n), .abort_n(abort_n),
        .bus_req_o(bus_req_o), .grant_out_n(grant_out_n), .own_o(own_o),
        .end_o(end_o), .cause_o(cause_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s [%s] actual=%0d expected=%0d at %0t", req, tag, act, exp, $time);
        end
    endtask

    // drive one cycle: set inputs after the falling edge, compare, advance model
    task automatic step(input bit w, input bit x, input bit g_n, input bit a_n, input int lim);
        bit e_req, e_own;
        want_i = w; xfer_i = x; grant_in_n = g_n; abort_n = a_n;
        dwell_lim_i = CNT_W'(lim);
        #1;
        e_req = (m_ph == 1) || (m_ph == 2);
        e_own = (m_ph == 2) && !g_n && a_n;
        chk("R2 bus_req_o", int'(bus_req_o), int'(e_req));
        chk("R10 grant_out_n", int'(grant_out_n), int'(g_n | e_req));
        chk("R3/R4 own_o", int'(own_o), int'(e_own));
        chk("R9 end_o", int'(end_o), int'(m_ph == 3));
        if (m_ph == 3) chk("R8 cause_o", int'(cause_o), m_cause);
        case (m_ph)
            0: if (w) m_ph = 1;
            1: begin
                if (!a_n)      begin m_ph = 3; m_cause = 3; end
                else if (!w)   begin m_ph = 3; m_cause = 0; end
                else if (!g_n) begin m_ph = 2; m_left = lim; m_free = (lim == 0); end
            end
            2: begin
                if (!a_n)                         begin m_ph = 3; m_cause = 3; end
                else if (g_n)                     begin m_ph = 3; m_cause = 2; end
                else if (x && !m_free && m_left == 1) begin m_ph = 3; m_cause = 1; end
                else if (!w)                      begin m_ph = 3; m_cause = 0; end
                else if (x && !m_free)            m_left--;
            end
            default: m_ph = 0;
        endcase
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        tag = "R1";
        chk("R1 reset bus_req_o", int'(bus_req_o), 0);
        chk("R1 reset own_o", int'(own_o), 0);
        chk("R1 reset end_o", int'(end_o), 0);
        rst = 1'b0;
        step(0, 0, 1, 1, 0);

        tag = "R10 pass-through";
        step(0, 0, 0, 1, 0); step(0, 0, 0, 1, 0); step(0, 0, 1, 1, 0);

        tag = "R2 R5 request, immediate grant, done";
        step(1, 0, 0, 1, 0); step(1, 0, 0, 1, 0); step(1, 1, 0, 1, 0);
        step(1, 1, 0, 1, 0); step(0, 0, 0, 1, 0); step(0, 0, 0, 1, 0);
        step(0, 0, 1, 1, 0);

        tag = "R3 late grant";
        step(1, 0, 1, 1, 0);
        for (int i = 0; i < 5; i++) step(1, 0, 1, 1, 0);
        step(1, 0, 0, 1, 0); step(1, 0, 0, 1, 0); step(0, 0, 0, 1, 0);
        step(0, 0, 1, 1, 0); step(0, 0, 1, 1, 0);

        tag = "R6 limit three";
        step(1, 0, 0, 1, 3); step(1, 0, 0, 1, 3);
        for (int i = 0; i < 3; i++) step(1, 1, 0, 1, 3);
        step(1, 0, 0, 1, 3); step(1, 0, 0, 1, 3); step(1, 0, 0, 1, 3);
        step(0, 0, 1, 1, 0); step(0, 0, 1, 1, 0);

        tag = "R6 limit one";
        step(1, 0, 0, 1, 1); step(1, 0, 0, 1, 1); step(1, 1, 0, 1, 1);
        step(0, 0, 0, 1, 1); step(0, 0, 1, 1, 1);

        tag = "R6 zero means unlimited";
        step(1, 0, 0, 1, 0); step(1, 0, 0, 1, 0);
        for (int i = 0; i < 20; i++) step(1, 1, 0, 1, 0);
        step(0, 0, 0, 1, 0); step(0, 0, 1, 1, 0); step(0, 0, 1, 1, 0);

        tag = "R7 pulses while not owned";
        step(1, 1, 1, 1, 2); step(1, 1, 1, 1, 2); step(1, 1, 0, 1, 2);
        step(1, 0, 0, 1, 2); step(1, 1, 0, 1, 2); step(1, 0, 0, 1, 2);
        step(1, 1, 0, 1, 2); step(0, 0, 1, 1, 0); step(0, 0, 1, 1, 0);

        tag = "R11 limit changed mid-tenure";
        step(1, 0, 0, 1, 2); step(1, 0, 0, 1, 2); step(1, 1, 0, 1, 9);
        step(1, 0, 0, 1, 1); step(1, 1, 0, 1, 7); step(1, 0, 0, 1, 0);
        step(0, 0, 1, 1, 0); step(0, 0, 1, 1, 0);

        tag = "R8 R4 grant withdrawn";
        step(1, 0, 0, 1, 0); step(1, 0, 0, 1, 0); step(1, 1, 0, 1, 0);
        step(1, 0, 1, 1, 0); step(1, 0, 1, 1, 0); step(1, 0, 1, 1, 0);
        step(0, 0, 1, 1, 0); step(0, 0, 1, 1, 0); step(0, 0, 1, 1, 0);

        tag = "R8 R4 abort while owning, priority";
        step(1, 0, 0, 1, 1); step(1, 0, 0, 1, 1); step(0, 1, 1, 0, 1);
        step(0, 0, 1, 1, 0); step(0, 0, 1, 1, 0);

        tag = "R8 abort while waiting";
        step(1, 0, 1, 1, 0); step(1, 0, 1, 0, 0); step(1, 0, 1, 1, 0);
        step(0, 0, 1, 1, 0); step(0, 0, 1, 1, 0); step(0, 0, 1, 1, 0);

        tag = "R8 revoke beats limit";
        step(1, 0, 0, 1, 1); step(1, 0, 0, 1, 1); step(1, 1, 1, 1, 1);
        step(0, 0, 1, 1, 0); step(0, 0, 1, 1, 0);

        tag = "R5 want dropped while waiting";
        step(1, 0, 1, 1, 0); step(0, 0, 1, 1, 0); step(0, 0, 1, 1, 0);
        step(0, 0, 1, 1, 0);

        tag = "R9 back-to-back request";
        step(1, 0, 0, 1, 1); step(1, 0, 0, 1, 1); step(1, 1, 0, 1, 1);
        step(1, 0, 0, 1, 1); step(1, 0, 0, 1, 1); step(1, 0, 0, 1, 1);
        step(1, 0, 0, 1, 1); step(0, 0, 1, 1, 0); step(0, 0, 1, 1, 0);

        tag = "R2 R3 R6 R8 mixed random";
        for (int i = 0; i < 4000; i++)
            step(($urandom % 8) != 0, $urandom % 2, ($urandom % 6) == 0,
                 ($urandom % 40) != 0, $urandom % 5);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule